// File: doc/BRIEF.md
# Board Interrupt Collector and Register Bank

This block merges sixteen level-sensitive external interrupt lines into a single parent interrupt. A small register bank on a byte-addressed bus sits beside it. The bank holds ten general-purpose 32-bit registers: two LED data words, an LED control word, a switch word, three miscellaneous write words, a miscellaneous read word and two card-slot words. It also holds an enable mask and a source-identity register.

Each interrupt line is synchronised and then compared against a stored copy of its last seen level. When an enabled line changes, the block records which line changed and forwards that line's new level to the parent output. It records the line as a one-hot code in the source-identity register, overwriting the previous contents, so the register does not accumulate pending bits.

Software reads the source-identity register to find the line that last changed. It can also overwrite that register, or the enable mask, through the bus. A fixed filter limits which bits those two registers can hold.

Top module: `board_irq_bank`

## Requirements
- R1: After reset, every mapped register reads zero and `parent_irq_o` is 0.
- R2: The general-purpose registers are plain 32-bit storage, and each returns the last value written to it. Their byte offsets are 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4.
- R3: A read issued with `rd_en_i` high at a clock edge puts the selected value on `rdata_o` after that edge. `rdata_o` holds that value until the next read, even if the register is written in the meantime.
- R4: The source-identity register is at offset 0xD0. When input n changes, in either direction, while mask bit n is set, this register is loaded with only bit n set and all other bits cleared.
- R5: `parent_irq_o` takes the new level of an enabled input that changes. Changes on masked inputs leave both `parent_irq_o` and the source-identity register untouched.
- R6: The enable mask is at offset 0xC0, and bit n enables input n. Writes to the mask and to the source-identity register keep only the bits set in 0x000FEEFF, so inputs 8 and 12 can never be enabled.
- R7: Reads of an unmapped offset return zero, and writes to an unmapped offset change no register.
- R8: When several enabled inputs change in the same cycle, the lowest-numbered one is loaded into the source-identity register, and its level drives `parent_irq_o`.
- R9: The stored level of each input tracks that input whether or not it is enabled. Enabling a line that changed while masked produces no event, and its next change does produce one.
- R10: Each input passes two synchroniser flops before change detection. A change applied before clock edge k shows on `parent_irq_o` after edge k+2 and not after edge k+1.
- R11: If an interrupt load and a bus write to the source-identity register fall on the same edge, the interrupt load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| irq_i | input | 16 | External interrupt levels |
| rdata_o | output | 32 | Registered read data |
| parent_irq_o | output | 1 | Forwarded parent interrupt |

## Verification
The hardest case to reach from the ports is the collision in R11. An interrupt load and a bus write to the source-identity register must hit the same edge, and the load comes two synchroniser stages after the input changes. The bench raises the input at a falling edge. It counts two rising edges, then holds the write strobe across the third, so both updates land together. A further sequence changes a line while it is masked and then enables it, which checks that the stored level kept tracking the line and that no false event fires.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_IRQ = 16;
  localparam int NUM_GP  = 10;

  localparam logic [7:0]  OFF_MASK   = 8'hC0;
  localparam logic [7:0]  OFF_SETCLR = 8'hD0;
  localparam logic [31:0] WR_FILTER  = 32'h000F_EEFF;

  // byte offsets of the general-purpose storage words
  function automatic logic [7:0] gp_offset(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      7:       return 8'h90;
      8:       return 8'hE0;
      default: return 8'hE4;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_event.sv
module irq_event #(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] sync_i,
  input  logic [NUM_IRQ-1:0] enable_i,
  output logic               load_o,
  output logic [NUM_IRQ-1:0] onehot_o,
  output logic               parent_o
);
  logic [NUM_IRQ-1:0] level_q;
  logic [NUM_IRQ-1:0] hit;
  logic               win_level;

  // level vector follows every line, enabled or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= sync_i;
  end

  assign hit       = (sync_i ^ level_q) & enable_i;
  assign onehot_o  = hit & (~hit + NUM_IRQ'(1));  // lowest set bit wins
  assign load_o    = |hit;
  assign win_level = |(sync_i & onehot_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     parent_o <= 1'b0;
    else if (load_o) parent_o <= win_level;
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import board_irq_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter int          NUM_IRQ   = 16,
  parameter logic [31:0] WR_FILTER = 32'h000F_EEFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic               load_i,
  input  logic [NUM_IRQ-1:0] onehot_i,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [DATA_W-1:0]  setclr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_SETCLR = ADDR_W'(OFF_SETCLR);
  localparam logic [DATA_W-1:0] FILT     = DATA_W'(WR_FILTER);

  logic [DATA_W-1:0] gp_view [NUM_GP];
  logic [DATA_W-1:0] mask_q, setclr_q, rd_val;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(gp_offset(g));
    logic [DATA_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       val_q <= '0;
      else if (wr_en_i && addr_i == OFF) val_q <= wdata_i;
    end
    assign gp_view[g] = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '0;
    else if (wr_en_i && addr_i == A_MASK) mask_q <= wdata_i & FILT;
  end

  // interrupt load takes precedence over a bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            setclr_q <= '0;
    else if (load_i)                        setclr_q <= DATA_W'(onehot_i);
    else if (wr_en_i && addr_i == A_SETCLR) setclr_q <= wdata_i & FILT;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_GP; i++)
      if (addr_i == ADDR_W'(gp_offset(i))) rd_val = gp_view[i];
    if (addr_i == A_MASK)   rd_val = mask_q;
    if (addr_i == A_SETCLR) rd_val = setclr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign mask_o   = mask_q[NUM_IRQ-1:0];
  assign setclr_o = setclr_q;
endmodule

// File: rtl/board_irq_bank.sv
module board_irq_bank #(
  parameter int          DATA_W      = board_irq_pkg::DATA_W,
  parameter int          ADDR_W      = board_irq_pkg::ADDR_W,
  parameter int          NUM_IRQ     = board_irq_pkg::NUM_IRQ,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] WR_FILTER   = board_irq_pkg::WR_FILTER
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               parent_irq_o
);
  logic [NUM_IRQ-1:0] irq_sync_w;
  logic [NUM_IRQ-1:0] mask_en;
  logic [NUM_IRQ-1:0] evt_onehot;
  logic               evt_load;
  logic [DATA_W-1:0]  setclr_val;

  irq_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(irq_sync_w)
  );

  irq_event #(.NUM_IRQ(NUM_IRQ)) u_event (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(irq_sync_w), .enable_i(mask_en),
    .load_o(evt_load), .onehot_o(evt_onehot), .parent_o(parent_irq_o)
  );

  irq_reg_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .WR_FILTER(WR_FILTER)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .load_i(evt_load),
    .onehot_i(evt_onehot), .mask_o(mask_en), .setclr_o(setclr_val),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/board_irq_bank_chk.sv
module board_irq_bank_chk
  import board_irq_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter int          NUM_IRQ   = 16,
  parameter logic [31:0] WR_FILTER = 32'h000F_EEFF
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               parent_irq_o,
  input logic               evt_load_i,
  input logic [NUM_IRQ-1:0] evt_onehot_i,
  input logic [DATA_W-1:0]  setclr_i,
  input logic [NUM_IRQ-1:0] mask_i
);
  logic mapped;
  always_comb begin
    mapped = (addr_i == ADDR_W'(OFF_MASK)) || (addr_i == ADDR_W'(OFF_SETCLR));
    for (int i = 0; i < NUM_GP; i++)
      if (addr_i == ADDR_W'(gp_offset(i))) mapped = 1'b1;
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_load_i |=> (setclr_i == DATA_W'($past(evt_onehot_i)))); // R4
  AST_PARENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_load_i |=> $stable(parent_irq_o)); // R5
  AST_MASK_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_MASK)) |=>
      (mask_i == ($past(wdata_i[NUM_IRQ-1:0]) & WR_FILTER[NUM_IRQ-1:0]))); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !mapped) |=> (rdata_o == '0)); // R7
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R3
  AST_SINGLE_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_onehot_i)); // R8
endmodule

bind board_irq_bank board_irq_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ), .WR_FILTER(WR_FILTER)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
  .parent_irq_o(parent_irq_o), .evt_load_i(evt_load),
  .evt_onehot_i(evt_onehot), .setclr_i(setclr_val), .mask_i(mask_en)
);

// File: tb/board_irq_bank_test.sv
module board_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] irq = '0;
  logic [31:0] rdata;
  logic        parent;
  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  localparam logic [7:0] A_MASK = 8'hC0, A_SC = 8'hD0;
  localparam logic [31:0] FILT = 32'h000F_EEFF;
  logic [7:0] gp_addr [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                               8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};

  always #2 clk = ~clk;

  board_irq_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr), .rd_en_i(rd), .irq_i(irq), .rdata_o(rdata),
    .parent_irq_o(parent)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 10; i++) bus_rd(gp_addr[i], 32'h0, "R1 gp");
    bus_rd(A_MASK, 32'h0, "R1 mask");
    bus_rd(A_SC, 32'h0, "R1 setclr");
    chk("R1 parent", {31'b0, parent}, 32'h0);
  endtask

  task automatic t_storage();
    for (int i = 0; i < 10; i++) bus_wr(gp_addr[i], 32'hA5000000 ^ (i * 32'h01010101));
    for (int i = 0; i < 10; i++) bus_rd(gp_addr[i], 32'hA5000000 ^ (i * 32'h01010101), "R2");
  endtask

  task automatic t_read_hold();
    bus_rd(8'h14, 32'hA5000000 ^ 32'h01010101, "R3 read");
    bus_wr(8'h14, 32'hDEADBEEF);
    repeat (3) @(negedge clk);
    chk("R3 hold", rdata, 32'hA5000000 ^ 32'h01010101);
    bus_rd(8'h14, 32'hDEADBEEF, "R3 new");
  endtask

  task automatic t_filter();
    bus_wr(A_MASK, 32'hFFFFFFFF);
    bus_rd(A_MASK, FILT, "R6 mask");
    bus_wr(A_SC, 32'hFFFFFFFF);
    bus_rd(A_SC, FILT, "R6 setclr");
    bus_wr(A_SC, 32'h0);
  endtask

  task automatic t_unmapped();
    bus_wr(8'h20, 32'h12345678);
    bus_rd(8'h20, 32'h0, "R7 read");
    bus_rd(8'h10, 32'hA5000000, "R7 no side effect");
    bus_rd(A_SC, 32'h0, "R7 setclr untouched");
  endtask

  task automatic t_latency();
    irq[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 not yet", {31'b0, parent}, 32'h0);
    @(negedge clk);
    chk("R10 arrived", {31'b0, parent}, 32'h1);
    bus_rd(A_SC, 32'h20, "R4 rise");
    irq[5] = 1'b0; settle();
    chk("R5 fall", {31'b0, parent}, 32'h0);
    bus_rd(A_SC, 32'h20, "R4 fall");
  endtask

  task automatic t_masked();
    bus_wr(A_SC, 32'h0);
    irq[8] = 1'b1; settle();
    chk("R6 line 8 blocked", {31'b0, parent}, 32'h0);
    bus_rd(A_SC, 32'h0, "R5 masked no load");
    irq[8] = 1'b0; settle();
  endtask

  task automatic t_level();
    bus_wr(A_MASK, 32'h0);
    irq[3] = 1'b1; settle();
    bus_rd(A_SC, 32'h0, "R5 disabled");
    bus_wr(A_MASK, 32'h0000FFFF); settle();
    bus_rd(A_SC, 32'h0, "R9 no event on enable");
    chk("R9 parent quiet", {31'b0, parent}, 32'h0);
    irq[3] = 1'b0; settle();
    bus_rd(A_SC, 32'h8, "R9 next change seen");
  endtask

  task automatic t_priority();
    bus_wr(A_SC, 32'h0);
    irq[2] = 1'b1; irq[9] = 1'b1; settle();
    bus_rd(A_SC, 32'h4, "R8 lowest wins");
    chk("R8 parent", {31'b0, parent}, 32'h1);
    irq[9] = 1'b0; irq[11] = 1'b1; settle();
    bus_rd(A_SC, 32'h200, "R8 second");
    chk("R8 parent follows winner", {31'b0, parent}, 32'h0);
  endtask

  task automatic t_collide();
    irq[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    addr = A_SC; wdata = 32'h0000ABCD; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    bus_rd(A_SC, 32'h10, "R11 load wins");
    chk("R11 parent", {31'b0, parent}, 32'h1);
    bus_wr(A_SC, 32'h0000ABCD);
    bus_rd(A_SC, 32'h0000ABCD & FILT, "R11 write alone");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_read_hold();
    t_filter();
    t_unmapped();
    bus_wr(A_MASK, 32'h0000FFFF);
    t_latency();
    t_masked();
    t_level();
    t_priority();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule